// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-line general-purpose I/O port on a plain byte-wide register bus: chip select, write enable, a 12-bit byte address and 8-bit write and read data. It keeps a per-pin direction register and an output value register. It drives a per-pin output value and output enable toward the pads, and it samples the pad inputs through a two-stage synchronizer.

Data accesses go through a window of addresses. Address bits 9 down to 2 form a pin mask: bit n+2 enables pin n for that access. Software can therefore set or clear a single pin with one write and does not need a read-modify-write sequence. A write only lands on pins that are already outputs. For that reason software sets the direction first and the value second. A read returns the driven value for output pins and the synchronized pad level for input pins. Positions outside the mask read as zero.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every pin is an input, pin_oe is all zero, pin_out is all zero and rdata is zero.
- R2: The direction register is at byte offset 0x400. It is written and read in full, and a 1 in bit n makes pin n an output (pin_oe[n] = 1).
- R3: The data window is every offset from 0x000 to 0x3FC with addr[1:0] = 0 and addr[11:10] = 0. Inside it, addr[n+2] is the access mask bit for pin n.
- R4: A data write changes only the pin_out bits whose mask bit is set. Every other bit keeps its previous value.
- R5: A data write does not change pin_out[n] for a pin that is an input at the time of the write. When the pin later becomes an output, it drives the value it held before that write.
- R6: A data read returns zero in every bit position whose mask bit is clear.
- R7: In a masked position, a data read returns the output register bit for an output pin and the synchronized pad bit for an input pin.
- R8: Input pins pass through two synchronizer flops. A pad change made before rising edge 1 is missed by a read captured at edge 2 and seen by a read captured at edge 3.
- R9: Read data appears on rdata one clock after the request edge, and rdata holds its value in every cycle with no read.
- R10: Accesses at unmapped offsets (nonzero addr[1:0], anything at or above 0x404, anything at or above 0x800) read as zero, and writes to them change neither the direction nor the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Access request in this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Per-pin output value |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
Writes are tried with a single-pin mask, a sparse two-pin mask, the full mask and the empty mask. This separates correct masking from whole-byte writes and from writes that ignore the address. Full-byte writes are made while some pins are inputs and are followed by a switch to output. This shows whether input pins silently kept the written value. Reads are made with a mixed direction setting, so the output register and the pad value each show up in their own bits. A pad toggle is read at consecutive edges to pin down the exact synchronizer depth. Misaligned, just-past-direction and high offsets check that unmapped accesses read as zero and leave the registers alone.

// File: rtl/gmp_pkg.sv
package gmp_pkg;
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_DATA_WR,
        ACC_DATA_RD,
        ACC_DIR_WR,
        ACC_DIR_RD,
        ACC_BAD_WR,
        ACC_BAD_RD
    } acc_e;
endpackage

// File: rtl/gmp_decode.sv
module gmp_decode
    import gmp_pkg::*;
#(
    parameter int          N_PINS     = 8,
    parameter int          ADDR_W     = 12,
    parameter logic [11:0] DIR_OFFSET = 12'h400
) (
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output acc_e              kind,
    output logic [N_PINS-1:0] mask
);
    localparam int MASK_LO = 2;
    localparam int MASK_HI = N_PINS + 1;

    logic in_window;
    logic at_dir;

    always_comb begin
        in_window = (addr[ADDR_W-1:MASK_HI+1] == '0) && (addr[1:0] == 2'b00);
        at_dir    = (addr == ADDR_W'(DIR_OFFSET));
        mask      = addr[MASK_HI:MASK_LO];
        kind      = ACC_IDLE;
        if (cs) begin
            if (in_window)   kind = we ? ACC_DATA_WR : ACC_DATA_RD;
            else if (at_dir) kind = we ? ACC_DIR_WR  : ACC_DIR_RD;
            else             kind = we ? ACC_BAD_WR  : ACC_BAD_RD;
        end
    end
endmodule

// File: rtl/gmp_sync.sv
module gmp_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stage;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stage[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stage[i] = s_q.stage[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stage[STAGES-1];
endmodule

// File: rtl/gmp_regs.sv
module gmp_regs
    import gmp_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              kind,
    input  logic [N_PINS-1:0] mask,
    input  logic [N_PINS-1:0] wdata,
    output logic [N_PINS-1:0] dir,
    output logic [N_PINS-1:0] outv
);
    typedef struct packed {
        logic [N_PINS-1:0] dir;
        logic [N_PINS-1:0] outv;
    } regs_t;

    regs_t r_d, r_q;
    logic [N_PINS-1:0] touch;

    always_comb begin
        r_d   = r_q;
        touch = mask & r_q.dir;
        case (kind)
            ACC_DIR_WR:  r_d.dir  = wdata;
            ACC_DATA_WR: r_d.outv = (r_q.outv & ~touch) | (wdata & touch);
            default:     ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dir  = r_q.dir;
    assign outv = r_q.outv;

    AST_INPUT_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((outv ^ $past(outv)) & ~$past(dir)) == '0)); // R5

    AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_DATA_WR) |=> (((outv ^ $past(outv)) & ~$past(mask)) == '0)); // R4

    AST_BAD_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_BAD_WR) |=> ($stable(outv) && $stable(dir))); // R10
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gmp_pkg::*;
#(
    parameter int          N_PINS     = 8,
    parameter int          ADDR_W     = 12,
    parameter int          SYNC_DEPTH = 2,
    parameter logic [11:0] DIR_OFFSET = 12'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_PINS-1:0] wdata,
    output logic [N_PINS-1:0] rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe
);
    acc_e              kind;
    logic [N_PINS-1:0] mask;
    logic [N_PINS-1:0] dir;
    logic [N_PINS-1:0] outv;
    logic [N_PINS-1:0] pads_sync;

    gmp_decode #(.N_PINS(N_PINS), .ADDR_W(ADDR_W), .DIR_OFFSET(DIR_OFFSET)) u_decode (
        .cs   (cs),
        .we   (we),
        .addr (addr),
        .kind (kind),
        .mask (mask)
    );

    gmp_sync #(.W(N_PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pads_sync)
    );

    gmp_regs #(.N_PINS(N_PINS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .mask  (mask),
        .wdata (wdata),
        .dir   (dir),
        .outv  (outv)
    );

    typedef struct packed {
        logic [N_PINS-1:0] rd;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        case (kind)
            ACC_DATA_RD: rd_d.rd = ((dir & outv) | (~dir & pads_sync)) & mask;
            ACC_DIR_RD:  rd_d.rd = dir;
            ACC_BAD_RD:  rd_d.rd = '0;
            default:     ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata   = rd_q.rd;
    assign pin_out = outv;
    assign pin_oe  = dir;

    AST_READ_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !we && addr[ADDR_W-1:N_PINS+2] == '0 && addr[1:0] == 2'b00)
        |=> ((rdata & ~$past(addr[N_PINS+1:2])) == '0)); // R6

    AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !we && addr[1:0] != 2'b00) |=> (rdata == '0)); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !(cs && !we)) |=> $stable(rdata)); // R9

    AST_IDLE_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !cs) |=> ($stable(pin_out) && $stable(pin_oe))); // R4
endmodule

// File: tb/gpio_mask_port_bench.sv
module gpio_mask_port_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mask_port u_gpio_mask_port (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
        cs = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1", "pin_oe after reset", pin_oe, 8'h00);
        check("R1", "pin_out after reset", pin_out, 8'h00);
        check("R1", "rdata after reset", rdata, 8'h00);
        bus_read(12'h400, v);
        check("R1", "direction after reset", v, 8'h00);
    endtask

    task automatic t_input_write_dropped();
        bus_write(12'h3FC, 8'hFF);
        check("R5", "write with all pins input", pin_out, 8'h00);
    endtask

    task automatic t_direction();
        logic [7:0] v;
        bus_write(12'h400, 8'hF0);
        bus_read(12'h400, v);
        check("R2", "direction readback", v, 8'hF0);
        check("R2", "pin_oe follows direction", pin_oe, 8'hF0);
    endtask

    task automatic t_partial_output_write();
        bus_write(12'h3FC, 8'hFF);
        check("R5", "full write with low nibble input", pin_out, 8'hF0);
        bus_write(12'h400, 8'hFF);
        check("R5", "after switching low nibble to output", pin_out, 8'hF0);
    endtask

    task automatic t_masked_writes();
        bus_write(12'h004, 8'hFF);
        check("R3", "mask pin0 only", pin_out, 8'hF1);
        bus_write(12'h240, 8'h00);
        check("R4", "mask pins 4 and 7 cleared", pin_out, 8'h61);
        bus_write(12'h000, 8'hFF);
        check("R4", "empty mask write", pin_out, 8'h61);
    endtask

    task automatic t_reads();
        logic [7:0] v;
        bus_write(12'h400, 8'h0F);
        @(negedge clk); pin_in = 8'hA5;
        repeat (4) @(negedge clk);
        bus_read(12'h3FC, v);
        check("R7", "mixed direction full read", v, 8'hA1);
        bus_read(12'h084, v);
        check("R6", "read mask pins 0 and 5", v, 8'h21);
        bus_read(12'h000, v);
        check("R6", "read with empty mask", v, 8'h00);
    endtask

    task automatic t_rdata_hold();
        logic [7:0] v;
        bus_read(12'h400, v);
        check("R9", "direction read", v, 8'h0F);
        repeat (3) @(negedge clk);
        check("R9", "rdata held while idle", rdata, 8'h0F);
    endtask

    task automatic t_sync_depth();
        @(negedge clk);
        pin_in = 8'h25;
        cs = 1'b1; we = 1'b0; addr = 12'h200;
        @(negedge clk);
        check("R8", "read at edge 1", rdata, 8'h80);
        @(negedge clk);
        check("R8", "read at edge 2", rdata, 8'h80);
        @(negedge clk);
        check("R8", "read at edge 3", rdata, 8'h00);
        cs = 1'b0;
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        bus_read(12'h404, v);
        check("R10", "read 0x404", v, 8'h00);
        bus_read(12'h3FD, v);
        check("R10", "misaligned read", v, 8'h00);
        bus_write(12'h404, 8'hFF);
        bus_write(12'hC00, 8'h00);
        bus_read(12'h400, v);
        check("R10", "direction after unmapped writes", v, 8'h0F);
        bus_write(12'h3FE, 8'h00);
        bus_write(12'h804, 8'h00);
        check("R10", "pin_out after unmapped writes", pin_out, 8'h61);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_input_write_dropped();
        t_direction();
        t_partial_output_write();
        t_masked_writes();
        t_reads();
        t_rdata_hold();
        t_sync_depth();
        t_unmapped();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule